// File: doc/BRIEF.md
# Serial Transmitter with Empty and Complete Flags

This block is the transmit half of an asynchronous serial port. A host bus reaches it through a small register file. Through that file the host sets a 12-bit baud divisor, selects the character length and picks normal or double-speed timing. Writing the data register queues a character. The block moves the character into a shift register and sends it on a single line as a frame. The frame is a low start bit, then the data bits with the least significant bit first, then a high stop bit. The line idles high.

Two flags follow the transmit path. The data-empty flag says the holding register can take another character. The done flag says the last frame has left the line and nothing else is queued. Each flag can raise an interrupt request when its own enable and the global interrupt enable input are both high. The requests carry two adjacent vector numbers. The data-empty source has priority. When the matching acknowledge arrives, the flag of that source clears.

Top module: `serial_tx_unit`

## Requirements
- R1: After reset the line is high, no interrupt is requested, and the status register (address 0) reads 0x20: the data-empty flag is set and the done flag is clear.
- R2: With the double-speed bit (bit 1 of address 0) clear, every bit slot lasts 16×(divisor+1) clocks. The divisor is address 3 (low 8 bits) together with bits 3:0 of address 4 (high 4 bits).
- R3: With the double-speed bit set, every bit slot lasts 8×(divisor+1) clocks.
- R4: The size code is {bit 2 of address 1, bits 2:1 of address 2}. Codes 0 to 3 give 5 to 8 data bits and code 7 gives 9 data bits. The unused codes 4 to 6 give 8 bits. The ninth bit is taken from bit 0 of address 1 when the character is written.
- R5: A frame is a low start bit, the data bits with the least significant first, and a high stop bit. When the transmitter is idle, the start bit begins on the clock edge that follows the data write.
- R6: A write to the data register (address 5) while the transmit enable (bit 3 of address 1) is clear is ignored. The empty flag stays set and the line stays high.
- R7: The data-empty flag (bit 5 of address 0) clears on an accepted data write. It sets again when the character moves into the shift register. Bus writes to it have no effect.
- R8: The done flag (bit 6 of address 0) sets when a stop bit ends with nothing queued, and writing 1 to it clears it. When a character is queued at the end of a stop bit, its start bit follows at once and the done flag stays clear.
- R9: A request is made only while the global enable is high and the source is both enabled and flagged. The data-empty source uses bit 5 of address 1 and identifier VEC_BASE. The done source uses bit 6 of address 1 and identifier VEC_BASE+1. The data-empty source has priority.
- R10: An acknowledge with identifier VEC_BASE clears the data-empty flag, and one with identifier VEC_BASE+1 clears the done flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 8 | Register write data |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | 8 | Register read data (combinational) |
| gie_i | input | 1 | Global interrupt enable |
| ack_i | input | 1 | Interrupt acknowledge strobe |
| ack_id_i | input | 8 | Identifier of the source being acknowledged |
| irq_o | output | 1 | Interrupt request |
| irq_id_o | output | 8 | Identifier of the highest-priority pending source |
| tx_o | output | 1 | Serial output line |

## Verification
Random frames use divisors 0 to 3 in both speed modes, so a wrong oversampling factor or an off-by-one in the divisor shows up as a shifted sample or a late done flag. Random data with every size code, including an unused one, checks that the bit count and the ninth-bit source are right. It also catches a reversed bit order, which would flip the samples. Directed cases queue a second character during a frame to see the start bit follow the stop bit with no gap, and write data with the transmitter disabled. They also try interrupt gating with the global enable low and high, and acknowledge each source in turn to show it clears only its own flag.

// File: rtl/stx_pkg.sv
package stx_pkg;
  localparam logic [2:0] A_STAT = 3'd0;
  localparam logic [2:0] A_CTLB = 3'd1;
  localparam logic [2:0] A_CTLC = 3'd2;
  localparam logic [2:0] A_DIVL = 3'd3;
  localparam logic [2:0] A_DIVH = 3'd4;
  localparam logic [2:0] A_DATA = 3'd5;

  typedef enum logic [1:0] {
    TXS_IDLE  = 2'd0,
    TXS_START = 2'd1,
    TXS_DATA  = 2'd2,
    TXS_STOP  = 2'd3
  } txs_e;

  // size code -> number of data bits per frame
  function automatic logic [3:0] code_to_bits(input logic [2:0] code);
    case (code)
      3'd0:    code_to_bits = 4'd5;
      3'd1:    code_to_bits = 4'd6;
      3'd2:    code_to_bits = 4'd7;
      3'd7:    code_to_bits = 4'd9;
      default: code_to_bits = 4'd8;
    endcase
  endfunction
endpackage

// File: rtl/stx_baud.sv
module stx_baud #(
  parameter int DIV_W     = 12,
  parameter int OS_NORMAL = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             dbl_i,
  output logic             bit_tick_o
);
  localparam int OS_W  = $clog2(OS_NORMAL);
  localparam int PER_W = DIV_W + OS_W + 1;
  localparam logic [OS_W-1:0] OS_LAST_N = OS_W'(OS_NORMAL - 1);
  localparam logic [OS_W-1:0] OS_LAST_D = OS_W'(OS_NORMAL / 2 - 1);

  // clocks in one bit slot
  function automatic logic [PER_W-1:0] bit_clocks(input logic [DIV_W-1:0] d, input logic dbl);
    logic [PER_W-1:0] base;
    base = PER_W'(d) + PER_W'(1);
    bit_clocks = dbl ? base * PER_W'(OS_NORMAL / 2) : base * PER_W'(OS_NORMAL);
  endfunction

  logic [DIV_W-1:0] pre_q;
  logic [OS_W-1:0]  os_q;
  logic [OS_W-1:0]  os_last;
  logic             pre_wrap;

  assign os_last    = dbl_i ? OS_LAST_D : OS_LAST_N;
  assign pre_wrap   = (pre_q == '0);
  assign bit_tick_o = run_i & pre_wrap & (os_q == os_last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      os_q  <= '0;
    end else if (!run_i) begin
      pre_q <= div_i;
      os_q  <= '0;
    end else if (pre_wrap) begin
      pre_q <= div_i;
      os_q  <= (os_q == os_last) ? '0 : os_q + OS_W'(1);
    end else begin
      pre_q <= pre_q - DIV_W'(1);
    end
  end

  // slot length monitor (divisor and mode are held while a frame runs)
  logic [PER_W-1:0] per_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   per_q <= '0;
    else if (!run_i || bit_tick_o) per_q <= '0;
    else                           per_q <= per_q + PER_W'(1);
  end

  p_slot_len_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_tick_o && !dbl_i) |-> (per_q == bit_clocks(div_i, 1'b0) - PER_W'(1)))
    else $error("slot length wrong, normal mode");
  p_slot_len_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_tick_o && dbl_i) |-> (per_q == bit_clocks(div_i, 1'b1) - PER_W'(1)))
    else $error("slot length wrong, double speed");
endmodule

// File: rtl/stx_shift.sv
module stx_shift #(
  parameter int MAX_BITS = 9,
  parameter int CNT_W    = $clog2(MAX_BITS + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bit_tick_i,
  input  logic                pend_i,
  input  logic [MAX_BITS-1:0] pend_data_i,
  input  logic [CNT_W-1:0]    nbits_i,
  output logic                take_o,
  output logic                busy_o,
  output logic                frame_end_o,
  output logic                tx_o
);
  import stx_pkg::*;

  txs_e                state_q;
  logic [MAX_BITS-1:0] sh_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [CNT_W-1:0]    len_q;
  logic                last_data;

  assign frame_end_o = (state_q == TXS_STOP) & bit_tick_i;
  assign take_o      = pend_i & ((state_q == TXS_IDLE) | frame_end_o);
  assign busy_o      = (state_q != TXS_IDLE);
  assign last_data   = (cnt_q == len_q - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TXS_IDLE;
      sh_q    <= '0;
      cnt_q   <= '0;
      len_q   <= '0;
    end else if (take_o) begin
      state_q <= TXS_START;
      sh_q    <= pend_data_i;
      len_q   <= nbits_i;
      cnt_q   <= '0;
    end else if (bit_tick_i) begin
      case (state_q)
        TXS_START: state_q <= TXS_DATA;
        TXS_DATA: begin
          sh_q <= sh_q >> 1;
          if (last_data) state_q <= TXS_STOP;
          else           cnt_q   <= cnt_q + CNT_W'(1);
        end
        TXS_STOP: state_q <= TXS_IDLE;
        default:  state_q <= TXS_IDLE;
      endcase
    end
  end

  always_comb begin
    case (state_q)
      TXS_START: tx_o = 1'b0;
      TXS_DATA:  tx_o = sh_q[0];
      default:   tx_o = 1'b1;
    endcase
  end

  p_start_after_take_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |=> !tx_o) else $error("start bit missing after load");
  p_len_in_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (len_q >= CNT_W'(5) && len_q <= CNT_W'(MAX_BITS)))
    else $error("frame length out of range");
endmodule

// File: rtl/stx_irq.sv
module stx_irq #(
  parameter int               VEC_W    = 8,
  parameter logic [VEC_W-1:0] VEC_BASE = 8'h12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             gie_i,
  input  logic             ie_empty_i,
  input  logic             ie_done_i,
  input  logic             flag_empty_i,
  input  logic             flag_done_i,
  input  logic             ack_i,
  input  logic [VEC_W-1:0] ack_id_i,
  output logic             irq_o,
  output logic [VEC_W-1:0] irq_id_o,
  output logic             ack_empty_o,
  output logic             ack_done_o
);
  localparam logic [VEC_W-1:0] VEC_EMPTY = VEC_BASE;
  localparam logic [VEC_W-1:0] VEC_DONE  = VEC_BASE + VEC_W'(1);

  logic req_empty, req_done;

  assign req_empty   = gie_i & ie_empty_i & flag_empty_i;
  assign req_done    = gie_i & ie_done_i & flag_done_i;
  assign irq_o       = req_empty | req_done;
  assign irq_id_o    = req_empty ? VEC_EMPTY : (req_done ? VEC_DONE : '0);
  assign ack_empty_o = ack_i & (ack_id_i == VEC_EMPTY);
  assign ack_done_o  = ack_i & (ack_id_i == VEC_DONE);

  p_gated_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gie_i |-> !irq_o) else $error("request while globally disabled");
  p_prio_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && flag_empty_i && ie_empty_i) |-> (irq_id_o == VEC_EMPTY))
    else $error("wrong source priority");
endmodule

// File: rtl/serial_tx_unit.sv
module serial_tx_unit #(
  parameter int         DIV_W     = 12,
  parameter int         OS_NORMAL = 16,
  parameter int         VEC_W     = 8,
  parameter logic [7:0] VEC_BASE  = 8'h12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [2:0]       wr_addr_i,
  input  logic [7:0]       wr_data_i,
  input  logic [2:0]       rd_addr_i,
  output logic [7:0]       rd_data_o,
  input  logic             gie_i,
  input  logic             ack_i,
  input  logic [VEC_W-1:0] ack_id_i,
  output logic             irq_o,
  output logic [VEC_W-1:0] irq_id_o,
  output logic             tx_o
);
  import stx_pkg::*;

  localparam int MAX_BITS = 9;
  localparam int CNT_W    = $clog2(MAX_BITS + 1);
  localparam int DIVH_W   = DIV_W - 8;
  localparam logic [7:0] CTLB_MASK = 8'b0110_1101;
  localparam logic [7:0] CTLC_MASK = 8'b0000_0110;

  logic                dbl_q, txc_q, udre_q, full_q;
  logic [7:0]          ctlb_q, ctlc_q;
  logic [DIV_W-1:0]    div_q;
  logic [MAX_BITS-1:0] buf_q;

  // named events
  logic wr_stat, wr_data_ok, take, busy, frame_end, bit_tick;
  logic ack_empty, ack_done;
  logic [CNT_W-1:0] nbits;

  assign wr_stat    = wr_en_i & (wr_addr_i == A_STAT);
  assign wr_data_ok = wr_en_i & (wr_addr_i == A_DATA) & ctlb_q[3];
  assign nbits      = CNT_W'(code_to_bits({ctlb_q[2], ctlc_q[2:1]}));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dbl_q  <= 1'b0;
      ctlb_q <= '0;
      ctlc_q <= '0;
      div_q  <= '0;
    end else if (wr_en_i) begin
      case (wr_addr_i)
        A_STAT: dbl_q  <= wr_data_i[1];
        A_CTLB: ctlb_q <= wr_data_i & CTLB_MASK;
        A_CTLC: ctlc_q <= wr_data_i & CTLC_MASK;
        A_DIVL: div_q[7:0] <= wr_data_i;
        A_DIVH: div_q[DIV_W-1:8] <= wr_data_i[DIVH_W-1:0];
        default: ;
      endcase
    end
  end

  // holding register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      buf_q  <= '0;
    end else begin
      if (take) full_q <= 1'b0;
      if (wr_data_ok) begin
        full_q <= 1'b1;
        buf_q  <= {ctlb_q[0], wr_data_i};
      end
    end
  end

  // flags: later statements take precedence
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      udre_q <= 1'b1;
      txc_q  <= 1'b0;
    end else begin
      if (ack_empty)  udre_q <= 1'b0;
      if (take)       udre_q <= 1'b1;
      if (wr_data_ok) udre_q <= 1'b0;
      if (ack_done)                 txc_q <= 1'b0;
      if (wr_stat && wr_data_i[6])  txc_q <= 1'b0;
      if (frame_end && !full_q)     txc_q <= 1'b1;
    end
  end

  always_comb begin
    case (rd_addr_i)
      A_STAT:  rd_data_o = {1'b0, txc_q, udre_q, 3'b000, dbl_q, 1'b0};
      A_CTLB:  rd_data_o = ctlb_q;
      A_CTLC:  rd_data_o = ctlc_q;
      A_DIVL:  rd_data_o = div_q[7:0];
      A_DIVH:  rd_data_o = 8'(div_q[DIV_W-1:8]);
      default: rd_data_o = 8'h00;
    endcase
  end

  stx_baud #(.DIV_W(DIV_W), .OS_NORMAL(OS_NORMAL)) u_baud (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(busy), .div_i(div_q),
    .dbl_i(dbl_q), .bit_tick_o(bit_tick)
  );

  stx_shift #(.MAX_BITS(MAX_BITS), .CNT_W(CNT_W)) u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni), .bit_tick_i(bit_tick),
    .pend_i(full_q), .pend_data_i(buf_q), .nbits_i(nbits),
    .take_o(take), .busy_o(busy), .frame_end_o(frame_end), .tx_o(tx_o)
  );

  stx_irq #(.VEC_W(VEC_W), .VEC_BASE(VEC_W'(VEC_BASE))) u_irq (
    .clk_i(clk_i), .rst_ni(rst_ni), .gie_i(gie_i),
    .ie_empty_i(ctlb_q[5]), .ie_done_i(ctlb_q[6]),
    .flag_empty_i(udre_q), .flag_done_i(txc_q),
    .ack_i(ack_i), .ack_id_i(ack_id_i), .irq_o(irq_o), .irq_id_o(irq_id_o),
    .ack_empty_o(ack_empty), .ack_done_o(ack_done)
  );

  p_empty_on_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && !wr_data_ok) |=> udre_q) else $error("empty flag not set on load");
  p_ignored_write_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == A_DATA && !ctlb_q[3] && !full_q) |=> !full_q)
    else $error("disabled write queued data");
  p_done_source_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(txc_q) |-> $past(frame_end)) else $error("done flag rose without frame end");
  p_ack_empty_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_empty && !take) |=> !udre_q) else $error("ack left empty flag set");
  p_ack_done_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_done && !frame_end) |=> !txc_q) else $error("ack left done flag set");
endmodule

// File: tb/test_serial_tx_unit.sv
module test_serial_tx_unit;
  localparam logic [7:0] BASE = 8'h12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       gie = 1'b0;
  logic       ack = 1'b0;
  logic [7:0] ack_id = '0;
  logic       irq;
  logic [7:0] irq_id;
  logic       tx;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  serial_tx_unit #(.VEC_BASE(BASE)) i_serial_tx_unit (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .gie_i(gie), .ack_i(ack), .ack_id_i(ack_id), .irq_o(irq),
    .irq_id_o(irq_id), .tx_o(tx)
  );

  function automatic int exp_bits(input logic [2:0] code);
    if (code == 3'd7) return 9;
    if (code > 3'd3)  return 8;
    return 5 + int'(code);
  endfunction

  function automatic int exp_period(input logic [11:0] dv, input logic dbl);
    return (int'(dv) + 1) * (dbl ? 8 : 16);
  endfunction

  function automatic logic [7:0] exp_stat(input logic txc, input logic udre, input logic dbl);
    return {1'b0, txc, udre, 3'b000, dbl, 1'b0};
  endfunction

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic setup(input logic [2:0] code, input logic [11:0] dv,
                       input logic dbl, input logic b9, input logic [7:0] ie);
    wr(3'd4, {4'b0, dv[11:8]});
    wr(3'd3, dv[7:0]);
    wr(3'd0, 8'h40 | {6'b0, dbl, 1'b0});
    wr(3'd2, {5'b0, code[1:0], 1'b0});
    wr(3'd1, ie | 8'h08 | {5'b0, code[2], 1'b0, b9});
  endtask

  // send one frame and check every slot and the done flag timing
  task automatic send_check(input logic [8:0] d, input logic [2:0] code,
                            input logic [11:0] dv, input logic dbl);
    int n, p, cur;
    string rq;
    n = exp_bits(code);
    p = exp_period(dv, dbl);
    rq = dbl ? "R3" : "R2";
    setup(code, dv, dbl, d[8], 8'h00);
    check("R8 cleared", int'(rd_data), int'(exp_stat(1'b0, 1'b1, dbl)));
    wr(3'd5, d[7:0]);
    check("R7 empty clears on write", int'(rd_data[5]), 0);
    check("R5 idle before load", int'(tx), 1);
    @(negedge clk);
    check("R5 start follows write", int'(tx), 0);
    check("R7 empty sets on load", int'(rd_data[5]), 1);
    cur = 0;
    for (int s = 0; s < n + 2; s++) begin
      int tgt;
      logic e;
      tgt = s * p + p / 2;
      repeat (tgt - cur) @(negedge clk);
      cur = tgt;
      if (s == 0)          e = 1'b0;
      else if (s == n + 1) e = 1'b1;
      else                 e = d[s-1];
      check(s == 0 ? "R5 start" : (s == n + 1 ? "R5 stop" : "R4 data bit"), int'(tx), int'(e));
    end
    repeat ((n + 2) * p - 1 - cur) @(negedge clk);
    check({rq, " done not early"}, int'(rd_data[6]), 0);
    @(negedge clk);
    check({rq, " R8 done at stop end"}, int'(rd_data), int'(exp_stat(1'b1, 1'b1, dbl)));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [2:0] codes [6];
    codes = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd7, 3'd5};
    void'($urandom(32'h5eed_0123));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 line", int'(tx), 1);
    check("R1 irq", int'(irq), 0);
    check("R1 status", int'(rd_data), 8'h20);
    rst_n = 1'b1;
    @(negedge clk);

    // R6 write with transmitter disabled
    wr(3'd1, 8'h00);
    wr(3'd5, 8'h00);
    check("R6 empty kept", int'(rd_data[5]), 1);
    begin
      int lows = 0;
      repeat (100) begin @(negedge clk); if (!tx) lows++; end
      check("R6 line idle", lows, 0);
    end
    // R7 empty flag is read-only
    wr(3'd0, 8'h00);
    check("R7 read-only", int'(rd_data), 8'h20);

    // directed corner frames
    send_check(9'h1AA, 3'd7, 12'd0, 1'b1);
    send_check(9'h055, 3'd0, 12'd1, 1'b0);

    // random frames
    for (int i = 0; i < 24; i++) begin
      logic [8:0] d;
      logic [2:0] c;
      logic [11:0] dv;
      logic dbl;
      d   = 9'($urandom);
      c   = codes[$urandom % 6];
      dv  = 12'($urandom % 4);
      dbl = 1'($urandom);
      send_check(d, c, dv, dbl);
    end

    // R8 back-to-back: second char queued during first frame
    setup(3'd3, 12'd0, 1'b1, 1'b0, 8'h00);
    wr(3'd5, 8'hF0);
    @(negedge clk);
    wr(3'd5, 8'h0F);
    repeat (77) @(negedge clk);
    check("R8 stop bit of first", int'(tx), 1);
    @(negedge clk);
    check("R8 start follows stop", int'(tx), 0);
    check("R8 no done between", int'(rd_data[6]), 0);
    repeat (80) @(negedge clk);
    check("R8 done after second", int'(rd_data[6]), 1);
    check("R8 line idle", int'(tx), 1);

    // R9 / R10 interrupts
    wr(3'd0, 8'h00);
    wr(3'd1, 8'h68);
    check("R9 status both set", int'(rd_data), 8'h60);
    check("R9 gated off", int'(irq), 0);
    gie = 1'b1;
    @(negedge clk);
    check("R9 request", int'(irq), 1);
    check("R9 priority id", int'(irq_id), int'(BASE));
    ack = 1'b1; ack_id = BASE;
    @(negedge clk);
    ack = 1'b0;
    check("R10 empty cleared", int'(rd_data), 8'h40);
    check("R9 done id", int'(irq_id), int'(BASE) + 1);
    ack = 1'b1; ack_id = BASE + 8'd1;
    @(negedge clk);
    ack = 1'b0;
    check("R10 done cleared", int'(rd_data), 8'h00);
    check("R9 no request", int'(irq), 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule